// File: doc/BRIEF.md
# Combined Command-Address-Data SPI Sequencer

This block is a serial-flash style SPI master. Software fills a small register file with an opcode, an address, a size word for each of the two header phases and a data-phase word (byte count and direction), and then writes the run bit. In merged mode the sequencer lowers chip select once and shifts the opcode, then the address, then the data bytes. Transmit bytes come from a first-word-fall-through FIFO and received bytes go to a receive FIFO. A single completion flag, which drives the interrupt line, is set when the whole sequence is over.

With merged mode off, a run request performs only the data phase, as a transaction of its own with its own completion. Header phases run single-lane, single-data-rate. The sequencer refuses a merged request whose header sizes, lane or rate fields, or data length are outside what it supports. Clearing the run bit while busy aborts the sequence at once.

Register offsets (3-bit word address): 0 mode (bit 0 merged enable), 1 opcode, 2 opcode phase config, 3 address, 4 address phase config, 5 data word, 6 run, 7 status.

Top module: `cmbseq_spi`

## Requirements
- R1: With mode bit 0 clear, a run request (write 1 to bit 0 at offset 6 while idle) shifts only the data bytes, in one chip-select window, followed by one completion.
- R2: With mode bit 0 set, opcode bits, then address bits, then data bits are shifted in that order within one chip-select low window with no gap. The done flag (status bit 1) and the irq output rise in the same cycle that chip select is released.
- R3: SPI mode 0: SCK idles low whenever chip select is high, bits leave MSB first, MOSI is stable while SCK is high, and MISO is sampled on the SCK rising edge.
- R4: The opcode register holds bits [15:0]. A phase config word has lanes in [14:13], a DDR bit in [12] and size-minus-one in [7:0]. An opcode size of 7 sends bits [7:0] and a size of 15 sends bits [15:0].
- R5: An address size of 23 sends address bits [23:0] and a size of 31 sends bits [31:0], the upper byte first.
- R6: In merged mode a run request is refused, with no chip-select activity, and sticky status bit 3 is set, if the opcode size is not 7 or 15, the address size is not 23 or 31, any lane field is non-zero, any DDR bit is set, or the data length exceeds FIFO_DEPTH*4 bytes.
- R7: The data word has the byte count minus one in [LEN_W-1:0] and the receive direction in bit 16. When transmitting, one FIFO byte is popped per data byte. If the FIFO is empty, 0x00 is sent and sticky status bit 2 is set.
- R8: When receiving, MOSI stays 0 during data and each received byte is pushed to the receive FIFO. If rx_full is high, the byte is dropped and status bit 2 is set.
- R9: Status bits 1 to 3 are cleared by writing 1 to them, and irq follows status bit 1.
- R10: Status bit 0 reads 1 while a sequence is busy. Writes to offsets 0 to 5 are ignored while busy.
- R11: Writing 0 to bit 0 at offset 6 while busy returns chip select high and SCK low on the next cycle, with no completion.
- R12: Chip select rises one full SCK period after the falling edge that ends the last data bit, which is three half periods after its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_ready | output | 1 | Transmit FIFO pop |
| rx_valid | output | 1 | Receive FIFO push |
| rx_data | output | 8 | Received byte |
| rx_full | input | 1 | Receive FIFO full |

## Verification
Random sequences vary the merged mode, the 1- and 2-byte opcodes, the 3- and 4-byte addresses, the data length from 1 to 16 bytes and the direction. A slave model records every MOSI bit, so phase order, field truncation and bit order are each separated by comparing the bit streams. Directed cases drive a short transmit FIFO and a full receive FIFO, which separates the error flag from normal completion. Refused requests with one bad field at a time, register writes while busy, and an abort in mid-sequence check that nothing leaks onto the pins. The delay from the last SCK rise to the chip-select release is timed on every sequence.

// File: rtl/cmbseq_pkg.sv
package cmbseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_DATA,
      ST_TAIL
   } seq_state_t;

   localparam logic [2:0] OFS_MODE   = 3'd0;
   localparam logic [2:0] OFS_CMDVAL = 3'd1;
   localparam logic [2:0] OFS_CMDCFG = 3'd2;
   localparam logic [2:0] OFS_ADRVAL = 3'd3;
   localparam logic [2:0] OFS_ADRCFG = 3'd4;
   localparam logic [2:0] OFS_XFER   = 3'd5;
   localparam logic [2:0] OFS_RUN    = 3'd6;
   localparam logic [2:0] OFS_STAT   = 3'd7;

   typedef struct packed {
      logic [1:0] lanes;
      logic       ddr;
      logic [7:0] size;
   } phase_cfg_t;

   function automatic phase_cfg_t cfg_from_word(input logic [31:0] w);
      phase_cfg_t c;
      c.lanes = w[14:13];
      c.ddr   = w[12];
      c.size  = w[7:0];
      return c;
   endfunction

   function automatic logic [31:0] cfg_to_word(input phase_cfg_t c);
      return {17'd0, c.lanes, c.ddr, 4'd0, c.size};
   endfunction

endpackage

// File: rtl/cmbseq_regs.sv
module cmbseq_regs
   import cmbseq_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       addr,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   input  logic             busy,
   input  logic             done_set,
   input  logic             xerr_set,
   input  logic             rej_set,
   output logic             comb_en,
   output logic [15:0]      cmd_val,
   output phase_cfg_t       cmd_cfg,
   output logic [31:0]      adr_val,
   output phase_cfg_t       adr_cfg,
   output logic [LEN_W-1:0] len_m1,
   output logic             dir_rx,
   output logic             start_req,
   output logic             abort_req,
   output logic             irq
);

   logic done_q, xerr_q, rej_q;
   logic cfg_wr, clr_wr, run_wr;

   assign cfg_wr    = we && !busy;
   assign clr_wr    = we && (addr == OFS_STAT);
   assign run_wr    = we && (addr == OFS_RUN);
   assign start_req = run_wr && wdata[0] && !busy;
   assign abort_req = run_wr && !wdata[0] && busy;
   assign irq       = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         comb_en <= 1'b0;
         cmd_val <= '0;
         cmd_cfg <= '0;
         adr_val <= '0;
         adr_cfg <= '0;
         len_m1  <= '0;
         dir_rx  <= 1'b0;
         done_q  <= 1'b0;
         xerr_q  <= 1'b0;
         rej_q   <= 1'b0;
      end else begin
         if (cfg_wr) begin
            case (addr)
               OFS_MODE:   comb_en <= wdata[0];
               OFS_CMDVAL: cmd_val <= wdata[15:0];
               OFS_CMDCFG: cmd_cfg <= cfg_from_word(wdata);
               OFS_ADRVAL: adr_val <= wdata;
               OFS_ADRCFG: adr_cfg <= cfg_from_word(wdata);
               OFS_XFER: begin
                  len_m1 <= wdata[LEN_W-1:0];
                  dir_rx <= wdata[16];
               end
               default: ;
            endcase
         end
         done_q <= done_set | (done_q & ~(clr_wr & wdata[1]));
         xerr_q <= xerr_set | (xerr_q & ~(clr_wr & wdata[2]));
         rej_q  <= rej_set  | (rej_q  & ~(clr_wr & wdata[3]));
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_MODE:   rdata[0] = comb_en;
         OFS_CMDVAL: rdata[15:0] = cmd_val;
         OFS_CMDCFG: rdata = cfg_to_word(cmd_cfg);
         OFS_ADRVAL: rdata = adr_val;
         OFS_ADRCFG: rdata = cfg_to_word(adr_cfg);
         OFS_XFER: begin
            rdata[LEN_W-1:0] = len_m1;
            rdata[16]        = dir_rx;
         end
         OFS_RUN:    rdata[0] = busy;
         OFS_STAT:   rdata[3:0] = {rej_q, xerr_q, done_q, busy};
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/cmbseq_tick.sv
module cmbseq_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF < 1) begin : g_bad_half
         $error("cmbseq_tick: HALF must be at least 1");
      end

      if (HALF == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_divider
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/cmbseq_fsm.sv
module cmbseq_fsm
   import cmbseq_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int MAX_BYTES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             comb_en,
   input  logic [15:0]      cmd_val,
   input  phase_cfg_t       cmd_cfg,
   input  logic [31:0]      adr_val,
   input  phase_cfg_t       adr_cfg,
   input  logic [LEN_W-1:0] len_m1,
   input  logic             dir_rx,
   input  logic             tick,
   input  logic             miso,
   input  logic             tx_valid,
   input  logic [7:0]       tx_data,
   input  logic             rx_full,
   output logic             busy,
   output logic             sck,
   output logic             cs_n,
   output logic             mosi,
   output logic             tx_ready,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic             done_set,
   output logic             xerr_set,
   output logic             rej_set
);

   localparam logic [31:0] LEN_LIMIT = 32'(MAX_BYTES);

   seq_state_t       st_q;
   logic             sck_q, csn_q, tail_q;
   logic [31:0]      sh_q;
   logic [5:0]       bits_q;
   logic [LEN_W-1:0] left_q;
   logic [7:0]       rxs_q;

   logic       shifting, rise, fall, last_bit;
   logic       cmd_ok, adr_ok, len_ok, go, load_byte, rx_try;
   logic [5:0] cmd_nb, adr_nb;
   logic [7:0] byte_in;

   assign cmd_ok = (cmd_cfg.lanes == 2'd0) && !cmd_cfg.ddr &&
                   ((cmd_cfg.size == 8'd7) || (cmd_cfg.size == 8'd15));
   assign adr_ok = (adr_cfg.lanes == 2'd0) && !adr_cfg.ddr &&
                   ((adr_cfg.size == 8'd23) || (adr_cfg.size == 8'd31));
   assign len_ok = ({{(32-LEN_W){1'b0}}, len_m1} < LEN_LIMIT);

   assign go      = start && (!comb_en || (cmd_ok && adr_ok && len_ok));
   assign rej_set = start && comb_en && !(cmd_ok && adr_ok && len_ok);

   assign cmd_nb = cmd_cfg.size[5:0] + 6'd1;
   assign adr_nb = adr_cfg.size[5:0] + 6'd1;

   assign shifting = (st_q == ST_CMD) || (st_q == ST_ADDR) || (st_q == ST_DATA);
   assign rise     = tick && shifting && !sck_q;
   assign fall     = tick && shifting && sck_q;
   assign last_bit = (bits_q == 6'd1);

   assign load_byte = (go && !comb_en)
                    || (fall && last_bit && (st_q == ST_ADDR))
                    || (fall && last_bit && (st_q == ST_DATA) && (left_q != '0));
   assign byte_in   = (!dir_rx && tx_valid) ? tx_data : 8'h00;
   assign tx_ready  = load_byte && !dir_rx && tx_valid;

   assign rx_try   = fall && last_bit && (st_q == ST_DATA) && dir_rx;
   assign rx_valid = rx_try && !rx_full;
   assign rx_data  = rxs_q;

   assign xerr_set = (load_byte && !dir_rx && !tx_valid) || (rx_try && rx_full);
   assign done_set = (st_q == ST_TAIL) && tick && tail_q && !abort;

   assign busy = (st_q != ST_IDLE);
   assign sck  = sck_q;
   assign cs_n = csn_q;
   assign mosi = sh_q[31];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sck_q  <= 1'b0;
         csn_q  <= 1'b1;
         tail_q <= 1'b0;
         sh_q   <= '0;
         bits_q <= '0;
         left_q <= '0;
         rxs_q  <= '0;
      end else if (abort) begin
         st_q  <= ST_IDLE;
         sck_q <= 1'b0;
         csn_q <= 1'b1;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (go) begin
                  csn_q <= 1'b0;
                  sck_q <= 1'b0;
                  if (comb_en) begin
                     st_q   <= ST_CMD;
                     sh_q   <= {cmd_val, 16'h0000} << (6'd16 - cmd_nb);
                     bits_q <= cmd_nb;
                  end else begin
                     st_q   <= ST_DATA;
                     sh_q   <= {byte_in, 24'h000000};
                     bits_q <= 6'd8;
                     left_q <= len_m1;
                  end
               end
            end
            ST_CMD, ST_ADDR, ST_DATA: begin
               if (rise) begin
                  sck_q <= 1'b1;
                  if (st_q == ST_DATA)
                     rxs_q <= {rxs_q[6:0], miso};
               end
               if (fall) begin
                  sck_q  <= 1'b0;
                  sh_q   <= sh_q << 1;
                  bits_q <= bits_q - 6'd1;
                  if (last_bit) begin
                     if (st_q == ST_CMD) begin
                        st_q   <= ST_ADDR;
                        sh_q   <= adr_val << (6'd32 - adr_nb);
                        bits_q <= adr_nb;
                     end else if (st_q == ST_ADDR) begin
                        st_q   <= ST_DATA;
                        sh_q   <= {byte_in, 24'h000000};
                        bits_q <= 6'd8;
                        left_q <= len_m1;
                     end else if (left_q != '0) begin
                        sh_q   <= {byte_in, 24'h000000};
                        bits_q <= 6'd8;
                        left_q <= left_q - 1'b1;
                     end else begin
                        st_q   <= ST_TAIL;
                        tail_q <= 1'b0;
                     end
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  tail_q <= 1'b1;
                  if (tail_q) begin
                     st_q  <= ST_IDLE;
                     csn_q <= 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cmbseq_spi.sv
module cmbseq_spi
   import cmbseq_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int SCK_HALF   = 2,
   parameter int LEN_W      = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq,
   output logic        sck,
   output logic        cs_n,
   output logic        mosi,
   input  logic        miso,
   input  logic        tx_valid,
   input  logic [7:0]  tx_data,
   output logic        tx_ready,
   output logic        rx_valid,
   output logic [7:0]  rx_data,
   input  logic        rx_full
);

   localparam int MAX_BYTES = FIFO_DEPTH * 4;

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("cmbseq_spi: LEN_W must be 1..16");
      end
      if (FIFO_DEPTH < 1 || MAX_BYTES > (1 << LEN_W)) begin : g_bad_depth
         $error("cmbseq_spi: FIFO_DEPTH*4 must fit the length field");
      end
   endgenerate

   logic             busy, tick, start_req, abort_req;
   logic             done_set, xerr_set, cfg_rej;
   logic             comb_en, dir_rx;
   logic [15:0]      cmd_val;
   logic [31:0]      adr_val;
   phase_cfg_t       cmd_cfg, adr_cfg;
   logic [LEN_W-1:0] len_m1;

   cmbseq_regs #(.LEN_W(LEN_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .busy      (busy),
      .done_set  (done_set),
      .xerr_set  (xerr_set),
      .rej_set   (cfg_rej),
      .comb_en   (comb_en),
      .cmd_val   (cmd_val),
      .cmd_cfg   (cmd_cfg),
      .adr_val   (adr_val),
      .adr_cfg   (adr_cfg),
      .len_m1    (len_m1),
      .dir_rx    (dir_rx),
      .start_req (start_req),
      .abort_req (abort_req),
      .irq       (irq)
   );

   cmbseq_tick #(.HALF(SCK_HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   cmbseq_fsm #(.LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_req),
      .abort    (abort_req),
      .comb_en  (comb_en),
      .cmd_val  (cmd_val),
      .cmd_cfg  (cmd_cfg),
      .adr_val  (adr_val),
      .adr_cfg  (adr_cfg),
      .len_m1   (len_m1),
      .dir_rx   (dir_rx),
      .tick     (tick),
      .miso     (miso),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .rx_full  (rx_full),
      .busy     (busy),
      .sck      (sck),
      .cs_n     (cs_n),
      .mosi     (mosi),
      .tx_ready (tx_ready),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .done_set (done_set),
      .xerr_set (xerr_set),
      .rej_set  (cfg_rej)
   );

endmodule

// File: rtl/cmbseq_spi_chk.sv
module cmbseq_spi_chk (
   input logic clk,
   input logic rst_n,
   input logic sck,
   input logic cs_n,
   input logic mosi,
   input logic irq,
   input logic tx_ready,
   input logic tx_valid,
   input logic rx_valid,
   input logic rx_full,
   input logic abort_req,
   input logic cfg_rej
);

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck); // R3

   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi)); // R3

   AST_IRQ_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $rose(cs_n)); // R2

   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rej |=> cs_n); // R6

   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> tx_valid); // R7

   AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (!rx_full && !cs_n)); // R8

   AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> (cs_n && !sck && !irq)); // R11

endmodule

bind cmbseq_spi cmbseq_spi_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sck       (sck),
   .cs_n      (cs_n),
   .mosi      (mosi),
   .irq       (irq),
   .tx_ready  (tx_ready),
   .tx_valid  (tx_valid),
   .rx_valid  (rx_valid),
   .rx_full   (rx_full),
   .abort_req (abort_req),
   .cfg_rej   (cfg_rej)
);

// File: tb/cmbseq_spi_test.sv
`timescale 1ns/1ps
module cmbseq_spi_test;

   localparam int HALF  = 2;
   localparam int DEPTH = 4;
   localparam logic [2:0] A_MODE = 3'd0, A_CMDV = 3'd1, A_CMDC = 3'd2, A_ADRV = 3'd3,
                          A_ADRC = 3'd4, A_XFER = 3'd5, A_RUN = 3'd6, A_STAT = 3'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        irq, sck, cs_n, mosi, miso, tx_valid, tx_ready, rx_valid;
   logic [7:0]  tx_data, rx_data;
   logic        rx_full = 1'b0;

   int vec = 0;
   int miss = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   cmbseq_spi #(.FIFO_DEPTH(DEPTH), .SCK_HALF(HALF), .LEN_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck),
      .cs_n(cs_n), .mosi(mosi), .miso(miso), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_full(rx_full)
   );

   // slave model and FIFO models
   bit        cap [0:16383];
   bit        mb  [0:16383];
   int        cap_n = 0;
   int        cs_rise = 0, cs_fall = 0, irq_n = 0, rx_n = 0;
   realtime   t_lastrise = 0.0, t_csrise = 0.0;
   logic [7:0] txq [0:1023];
   logic [7:0] rxq [0:1023];
   int        tx_rd = 0, tx_wr = 0;
   logic      irq_prev = 1'b0;

   assign miso     = mb[cap_n];
   assign tx_valid = (tx_rd < tx_wr);
   assign tx_data  = txq[tx_rd];

   always @(posedge sck) if (!cs_n) begin
      cap[cap_n] = mosi;
      cap_n = cap_n + 1;
      t_lastrise = $realtime;
   end
   always @(posedge cs_n) begin cs_rise = cs_rise + 1; t_csrise = $realtime; end
   always @(negedge cs_n) cs_fall = cs_fall + 1;
   always @(posedge clk) begin
      if (tx_ready) tx_rd = tx_rd + 1;
      if (rx_valid) begin rxq[rx_n] = rx_data; rx_n = rx_n + 1; end
      if (irq && !irq_prev) irq_n = irq_n + 1;
      irq_prev = irq;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vec++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      bit ok = 0;
      for (int n = 0; n < 20000; n++) begin
         rd(A_STAT, s);
         if (!s[0]) begin ok = 1; break; end
      end
      chk(req, {63'd0, ok}, 64'd1);
   endtask

   function automatic bit fbit(input logic [31:0] v, input int nbits, input int i);
      return v[nbits - 1 - i];
   endfunction

   function automatic logic [31:0] cfg_word(input int nbytes);
      return 32'(nbytes * 8 - 1);
   endfunction

   task automatic run_txn(input bit comb, input int cnb, input logic [15:0] cval,
                          input int anb, input logic [31:0] aval, input int dn,
                          input bit rx, input int tx_avail, input bit full, input bit poke);
      bit          ex [0:255];
      logic [7:0]  db [0:31];
      int          nexp = 0, base, cs0, irq0, rx0, bad;
      logic [31:0] s;
      base = cap_n;
      if (comb) begin
         for (int i = 0; i < cnb * 8; i++) begin ex[nexp] = fbit({16'd0, cval}, cnb * 8, i); nexp++; end
         for (int i = 0; i < anb * 8; i++) begin ex[nexp] = fbit(aval, anb * 8, i); nexp++; end
      end
      for (int k = 0; k < dn; k++) begin
         db[k] = 8'($urandom);
         for (int b = 0; b < 8; b++) begin
            if (rx) begin
               mb[base + nexp] = db[k][7 - b];
               ex[nexp] = 1'b0;
            end else begin
               ex[nexp] = (k < tx_avail) ? db[k][7 - b] : 1'b0;
            end
            nexp++;
         end
      end
      if (!rx) for (int k = 0; k < tx_avail; k++) begin txq[tx_wr] = db[k]; tx_wr++; end
      rx_full = full;
      wr(A_MODE, {31'd0, comb});
      wr(A_CMDV, {16'd0, cval});
      wr(A_CMDC, cfg_word(cnb));
      wr(A_ADRV, aval);
      wr(A_ADRC, cfg_word(anb));
      wr(A_XFER, {15'd0, rx, 16'(dn - 1)});
      cs0 = cs_rise; irq0 = irq_n; rx0 = rx_n;
      wr(A_RUN, 32'd1);
      if (poke) begin
         rd(A_STAT, s);
         chk("R10 busy bit", {63'd0, s[0]}, 64'd1);
         wr(A_CMDV, {16'd0, ~cval});
         wr(A_MODE, {31'd0, ~comb});
         rd(A_CMDV, s);
         chk("R10 opcode kept", {32'd0, s}, {48'd0, cval});
         rd(A_MODE, s);
         chk("R10 mode kept", {63'd0, s[0]}, {63'd0, comb});
      end
      wait_idle("R2 completes");
      repeat (2) @(negedge clk);
      bad = 0;
      for (int i = 0; i < nexp; i++) if (cap[base + i] != ex[i]) bad++;
      chk(comb ? "R2 R4 R5 bit stream" : "R1 bit stream", 64'(bad), 64'd0);
      chk("R3 bit count", 64'(cap_n - base), 64'(nexp));
      chk("R2 one cs window", 64'(cs_rise - cs0), 64'd1);
      chk("R9 one irq", {63'(irq_n - irq0), irq}, {63'd1, 1'b1});
      chk("R12 tail", 64'($rtoi((t_csrise - t_lastrise) * 10.0 + 0.5)), 64'(3 * HALF * 50));
      if (rx) begin
         int rbad = 0;
         chk("R8 rx count", 64'(rx_n - rx0), full ? 64'd0 : 64'(dn));
         if (!full) for (int k = 0; k < dn; k++) if (rxq[rx0 + k] !== db[k]) rbad++;
         chk("R8 rx data", 64'(rbad), 64'd0);
      end
      rd(A_STAT, s);
      chk("R7 R8 error flag", {63'd0, s[2]}, {63'd0, ((!rx && tx_avail < dn) || (rx && full))});
      wr(A_STAT, 32'h0000000E);
      rd(A_STAT, s);
      chk("R9 flags cleared", {60'd0, s[3:0], irq}, 64'd0);
      rx_full = 1'b0;
   endtask

   task automatic reject(input string req, input logic [31:0] cc, input logic [31:0] ac, input int dn);
      logic [31:0] s;
      int f0;
      wr(A_MODE, 32'd1);
      wr(A_CMDC, cc);
      wr(A_ADRC, ac);
      wr(A_XFER, {16'd0, 16'(dn - 1)});
      f0 = cs_fall;
      wr(A_RUN, 32'd1);
      repeat (20) @(negedge clk);
      rd(A_STAT, s);
      chk(req, {59'd0, s[3:0], cs_n}, {59'd0, 4'b1000, 1'b1});
      chk(req, 64'(cs_fall - f0), 64'd0);
      wr(A_STAT, 32'h8);
   endtask

   initial begin
      logic [31:0] s;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_STAT, s);
      chk("R9 reset status", {59'd0, s[3:0], irq}, 64'd0);
      chk("R3 reset pins", {62'd0, cs_n, sck}, 64'd2);
      rd(A_MODE, s);
      chk("R1 reset mode", {32'd0, s}, 64'd0);

      // directed: each header size, long data, non-merged
      run_txn(1, 1, 16'h00A5, 3, 32'hFF123456, 4, 0, 4, 0, 0);
      run_txn(1, 2, 16'hC33C, 4, 32'h89ABCDEF, 2, 1, 0, 0, 0);
      run_txn(1, 1, 16'h0003, 4, 32'h00000001, DEPTH * 4, 0, DEPTH * 4, 0, 1);
      run_txn(0, 1, 16'h0055, 3, 32'h0, 3, 0, 3, 0, 0);
      run_txn(0, 1, 16'h0055, 3, 32'h0, 5, 1, 0, 0, 0);
      // R7 underflow, R8 overflow
      run_txn(1, 1, 16'h0002, 3, 32'h00ABCDEF, 5, 0, 3, 0, 0);
      run_txn(1, 1, 16'h000B, 3, 32'h00010203, 2, 1, 0, 1, 0);

      // R6 refusals, one bad field at a time
      reject("R6 opcode size", cfg_word(3), cfg_word(3), 1);
      reject("R6 addr size", cfg_word(1), cfg_word(2), 1);
      reject("R6 lanes", 32'h2000 | cfg_word(1), cfg_word(3), 1);
      reject("R6 ddr", cfg_word(1), 32'h1000 | cfg_word(4), 1);
      reject("R6 length", cfg_word(1), cfg_word(3), DEPTH * 4 + 1);

      // random mix
      for (int it = 0; it < 24; it++) begin
         bit c = ($urandom % 4) != 0;
         bit r = $urandom % 2;
         int n = 1 + ($urandom % (DEPTH * 4));
         run_txn(c, 1 + ($urandom % 2), 16'($urandom), 3 + ($urandom % 2), $urandom,
                 n, r, r ? 0 : n, 0, ($urandom % 3) == 0);
      end

      // R11 abort in mid sequence
      begin
         int i0;
         wr(A_MODE, 32'd1);
         wr(A_CMDC, cfg_word(1));
         wr(A_ADRC, cfg_word(4));
         wr(A_XFER, {15'd0, 1'b1, 16'd7});
         i0 = irq_n;
         wr(A_RUN, 32'd1);
         repeat (40) @(negedge clk);
         chk("R11 running before abort", {63'd0, cs_n}, 64'd0);
         wr(A_RUN, 32'd0);
         chk("R11 pins after abort", {62'd0, cs_n, sck}, 64'd2);
         repeat (200) @(negedge clk);
         rd(A_STAT, s);
         chk("R11 no completion", {59'd0, s[3:0], irq}, 64'd0);
         chk("R11 no irq", 64'(irq_n - i0), 64'd0);
      end

      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         vec++;
         miss++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
         $finish;
      end
   end

endmodule